// File: doc/BRIEF.md
# Constant-Time Ladder Sequencer

This block runs the control loop of a Montgomery-ladder scalar multiplication over an M-bit secret scalar. A start pulse loads a fixed starting point into the first point register and the base point into the second. The scalar bits are then walked from the top bit down to bit 0.

For every bit the block does three things in order. It first exchanges the two point registers when the bit is 1 and keeps them when it is 0. It then hands both registers and the base point to an external combined double-and-add engine and waits for that engine's done signal. Last, it repeats the same conditional exchange. The point registers are S words of W bits. The exchange works on one word per cycle, using an XOR mask built from the replicated key bit, so both registers are rewritten in every exchange cycle, whatever the bit is.

The order and number of steps never depend on the scalar. With an engine of fixed latency, the run time is the same for every key. A done pulse marks the end of a run.

Top module: `ladder_seq`

## Requirements
- R1: After reset, busy, done and eng_req are 0 and both point outputs v1 and v2 are zero.
- R2: On a clock edge with start high while idle, the scalar is captured, v1 is loaded with init_pt and v2 with base_pt, and processing begins at scalar bit M-1. Both loads are visible in the cycle that follows.
- R3: For each bit, working from bit M-1 down to bit 0, the block exchanges v1 and v2 when the bit is 1 (keeps them when 0). It then applies one engine step, taking v1 from eng_ra and v2 from eng_rb at an edge where eng_done is high, and then does the same exchange again. While the engine is busy the registers hold their values.
- R4: At the end of a run, v1 and v2 equal the result of that ladder computed on the captured inputs. With init_pt = 0 and an engine that maps (a, b) to (2a, a+b) modulo 2^(S*W), v1 = k*base_pt and v2 = (k+1)*base_pt.
- R5: eng_req is a pulse one cycle wide, issued exactly once per scalar bit, so M times per run. eng_a, eng_b and eng_base present the current v1, v2 and base point.
- R6: done is high for exactly one cycle, one cycle after the last exchange of bit 0, and busy is 0 in the cycle after done.
- R7: With an engine of fixed latency, the number of cycles from start to done is the same for every scalar value.
- R8: A start pulse while busy is ignored. The run in progress completes with the results of the scalar captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| scalar | input | M | Secret scalar, captured at start |
| base_pt | input | S*W | Base point, captured at start |
| init_pt | input | S*W | Fixed starting value for v1 |
| eng_req | output | 1 | One-cycle request to the double-and-add engine |
| eng_a | output | S*W | First operand to the engine (current v1) |
| eng_b | output | S*W | Second operand to the engine (current v2) |
| eng_base | output | S*W | Captured base point for the engine |
| eng_done | input | 1 | Engine result valid |
| eng_ra | input | S*W | Engine result for v1 |
| eng_rb | input | S*W | Engine result for v2 |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| v1 | output | S*W | First point register |
| v2 | output | S*W | Second point register |

## Verification
The loaded values are due one cycle after the start edge. The bench samples them at the following falling edge. Final values are due in the cycle where done is high, and the bench waits for done at falling edges and compares v1 and v2 there with a ladder model it computes itself. The stub engine has a fixed latency, so the bench can count cycles from start to done and count request pulses, and compare those counts across all-zero, all-one and mixed scalars. The ignored-start case raises start halfway through a run and then checks that the final values match the scalar captured first.

// File: rtl/ladder_seq.sv
module ladder_seq #(
  parameter int M = 16,
  parameter int S = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] scalar,
  input  logic [S*W-1:0] base_pt,
  input  logic [S*W-1:0] init_pt,
  output logic         eng_req,
  output logic [S*W-1:0] eng_a,
  output logic [S*W-1:0] eng_b,
  output logic [S*W-1:0] eng_base,
  input  logic         eng_done,
  input  logic [S*W-1:0] eng_ra,
  input  logic [S*W-1:0] eng_rb,
  output logic         busy,
  output logic         done,
  output logic [S*W-1:0] v1,
  output logic [S*W-1:0] v2
);
  localparam int N    = S * W;
  localparam int IDXW = (M > 1) ? $clog2(M) : 1;
  localparam int WSW  = (S > 1) ? $clog2(S) : 1;

  typedef enum logic [2:0] {IDLE, SW1, REQ, WAIT, SW2, FIN} st_t;

  st_t            st;
  logic [M-1:0]   key;
  logic [IDXW-1:0] idx;
  logic [WSW-1:0] wsel;
  logic [N-1:0]   pb;
  logic [N-1:0]   v1_sw, v2_sw;
  logic [W-1:0]   mask;
  logic           last_word;

  assign mask      = {W{key[idx]}};
  assign last_word = (wsel == WSW'(S - 1));

  for (genvar j = 0; j < S; j++) begin : g_word
    logic [W-1:0] diff;
    logic [W-1:0] flip;
    assign diff = v1[j*W +: W] ^ v2[j*W +: W];
    assign flip = (wsel == WSW'(j)) ? (diff & mask) : '0;
    assign v1_sw[j*W +: W] = v1[j*W +: W] ^ flip;
    assign v2_sw[j*W +: W] = v2[j*W +: W] ^ flip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      key  <= '0;
      idx  <= '0;
      wsel <= '0;
      pb   <= '0;
      v1   <= '0;
      v2   <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          v1   <= init_pt;
          v2   <= base_pt;
          pb   <= base_pt;
          key  <= scalar;
          idx  <= IDXW'(M - 1);
          wsel <= '0;
          st   <= SW1;
        end
        SW1: begin
          v1 <= v1_sw;
          v2 <= v2_sw;
          if (last_word) begin
            wsel <= '0;
            st   <= REQ;
          end else begin
            wsel <= wsel + WSW'(1);
          end
        end
        REQ: st <= WAIT;
        WAIT: if (eng_done) begin
          v1 <= eng_ra;
          v2 <= eng_rb;
          st <= SW2;
        end
        SW2: begin
          v1 <= v1_sw;
          v2 <= v2_sw;
          if (last_word) begin
            wsel <= '0;
            if (idx == '0) begin
              st <= FIN;
            end else begin
              idx <= idx - IDXW'(1);
              st  <= SW1;
            end
          end else begin
            wsel <= wsel + WSW'(1);
          end
        end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign eng_req  = (st == REQ);
  assign done     = (st == FIN);
  assign busy     = (st != IDLE);
  assign eng_a    = v1;
  assign eng_b    = v2;
  assign eng_base = pb;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start) |=> (idx == IDXW'(M - 1) && v1 == $past(init_pt) && v2 == $past(base_pt)));

  a_r3_bit_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW1 && $past(st) == SW2) |-> (idx == $past(idx) - IDXW'(1)));

  a_r3_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && !eng_done) |=> ($stable(v1) && $stable(v2)));

  a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r8_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(key));
endmodule

// File: tb/ladder_seq_tb.sv
`timescale 1ns/1ps
module ladder_seq_tb;
  localparam int M = 16;
  localparam int S = 4;
  localparam int W = 8;
  localparam int N = S * W;
  localparam int LAT = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [M-1:0] scalar = '0;
  logic [N-1:0] base_pt = '0, init_pt = '0;
  logic eng_req, eng_done, busy, done;
  logic [N-1:0] eng_a, eng_b, eng_base, eng_ra, eng_rb, v1, v2;

  int checks = 0;
  int fails = 0;
  int req_cnt = 0;
  int cnt = 0;

  always #2 clk = ~clk;

  ladder_seq #(.M(M), .S(S), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
    .base_pt(base_pt), .init_pt(init_pt), .eng_req(eng_req),
    .eng_a(eng_a), .eng_b(eng_b), .eng_base(eng_base),
    .eng_done(eng_done), .eng_ra(eng_ra), .eng_rb(eng_rb),
    .busy(busy), .done(done), .v1(v1), .v2(v2));

  always_ff @(posedge clk) begin
    if (eng_req) cnt <= LAT;
    else if (cnt > 0) cnt <= cnt - 1;
  end
  assign eng_done = (cnt == 1);
  assign eng_ra   = eng_a << 1;
  assign eng_rb   = eng_a + eng_b;

  always @(negedge clk) if (eng_req) req_cnt++;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] model(input logic [M-1:0] k, input logic [N-1:0] c, input logic [N-1:0] b);
    logic [N-1:0] a, d, t;
    a = c; d = b;
    for (int i = M - 1; i >= 0; i--) begin
      if (k[i]) begin t = a; a = d; d = t; end
      t = a << 1; d = a + d; a = t;
      if (k[i]) begin t = a; a = d; d = t; end
    end
    return {a, d};
  endfunction

  task automatic run(input logic [M-1:0] k, input logic [N-1:0] c, input logic [N-1:0] b,
                     input bit early_start, output int cycles);
    logic [2*N-1:0] exp;
    int guard;
    exp = model(k, c, b);
    @(negedge clk);
    scalar = k; init_pt = c; base_pt = b; start = 1;
    req_cnt = 0;
    @(negedge clk);
    start = 0;
    cycles = 1;
    check(v1 == c, "R2 v1 load", 64'(v1), 64'(c));
    check(v2 == b, "R2 v2 load", 64'(v2), 64'(b));
    guard = 0;
    while (!done && guard < 5000) begin
      if (early_start && guard == 40) begin
        scalar = ~k; base_pt = b + 1; init_pt = c + 3; start = 1;
      end else begin
        start = 0;
      end
      @(negedge clk);
      cycles++;
      guard++;
    end
    start = 0;
    check(guard < 5000, "R6 watchdog", 64'(guard), 64'(0));
    check(v1 == exp[2*N-1:N], early_start ? "R8 v1 first scalar" : "R3 R4 v1 final", 64'(v1), 64'(exp[2*N-1:N]));
    check(v2 == exp[N-1:0], early_start ? "R8 v2 first scalar" : "R3 R4 v2 final", 64'(v2), 64'(exp[N-1:0]));
    check(req_cnt == M, "R5 request count", 64'(req_cnt), 64'(M));
    @(negedge clk);
    check(!done && !busy, "R6 done single pulse", 64'({done, busy}), 64'(0));
  endtask

  task automatic test_reset;
    check(!busy && !done && !eng_req, "R1 control idle", 64'({busy, done, eng_req}), 64'(0));
    check(v1 == '0 && v2 == '0, "R1 points zero", 64'(v1 | v2), 64'(0));
  endtask

  task automatic test_group;
    int c0, c1, c2;
    logic [M-1:0] k;
    logic [N-1:0] b;
    k = 16'hA5C3; b = 32'd7;
    run(k, '0, b, 0, c0);
    check(v1 == N'(k) * b, "R4 v1 equals k*P", 64'(v1), 64'(N'(k) * b));
    check(v2 == (N'(k) + 1) * b, "R4 v2 equals (k+1)*P", 64'(v2), 64'((N'(k) + 1) * b));
    run('0, '0, 32'h1234_5678, 0, c1);
    run('1, '0, 32'h0000_0BAD, 0, c2);
    check(c0 == c1, "R7 cycles zero key", 64'(c1), 64'(c0));
    check(c0 == c2, "R7 cycles ones key", 64'(c2), 64'(c0));
  endtask

  task automatic test_const;
    int c;
    run(16'h8001, 32'hDEAD_0042, 32'h0101_0303, 0, c);
    run(16'h0F0F, 32'h0000_0011, 32'h7777_1111, 0, c);
  endtask

  task automatic test_busy_start;
    int c;
    run(16'h3C96, 32'h0000_0005, 32'h0000_0009, 1, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1;
    @(negedge clk);
    test_group;
    test_const;
    test_busy_start;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL R6 global watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule